// File: doc/BRIEF.md
# Multiplexed External Bus Sequencer

This block produces the external memory bus timing for a core that runs on a twelve-clock machine cycle. It divides the oscillator clock into machine cycles of six states, each state being two clock phases. From that timing base it drives an address latch strobe, an active-low code-read strobe, active-low data read and write strobes, a low port that carries the low address byte and then data, and a high port that carries the upper address bits.

In a normal machine cycle the bus makes two code fetches. Each fetch places the fetch address on the ports, pulses the latch strobe, then releases the low port and pulls the code-read strobe low so that external code memory can drive the byte back. The byte is captured just before the strobe rises. When code runs from internal memory the code-read strobe stays high, but the latch strobe keeps pulsing. A data access is requested at a machine-cycle boundary. It takes two machine cycles: the first is an ordinary fetch cycle, and in the second the block places the data address with one latch pulse, skips the second latch pulse and both fetches, and holds the read or write strobe low for most of the cycle. The data bus cycle therefore lasts about twice as long as a fetch.

The block also gives a one-clock tick at the end of each machine cycle and the current state and phase numbers, so that a timer or an instruction sequencer can step once per machine cycle.

Top module: `mxb_bus_seq`

## Requirements
- R1: A machine cycle is 12 clocks. `state_num` runs 1 to 6 and holds each value for two clocks, with `phase_num` 0 then 1. `cycle_tick` is high only in state 6 phase 1. Reset gives state 1 phase 0.
- R2: In a fetch cycle `ale` is high in state 1 phase 1, state 2 phase 0, state 4 phase 1 and state 5 phase 0, and low in every other slot.
- R3: With `ext_code`=1, in a fetch cycle `psen_n` is low from state 2 phase 1 through state 3 phase 1, and again from state 5 phase 1 through state 6 phase 1. `code_byte` takes the value on `bus_in` at the clock edge that ends state 3 phase 1, and again at the edge that ends state 6 phase 1.
- R4: With `ext_code`=0, `psen_n` stays high and `code_byte` does not change.
- R5: In a fetch cycle `port_lo_oe` is 1 from state 1 phase 0 through state 2 phase 0 and from state 4 phase 0 through state 5 phase 0, and 0 otherwise. While it is 1, `port_lo_out` equals `fetch_addr[7:0]`. `port_hi` equals `fetch_addr[15:8]` throughout the cycle.
- R6: `data_req` is sampled only at the clock edge that ends state 6 phase 1, and it is ignored at that edge when the cycle ending is the first cycle of an access. An accepted request makes the next machine cycle a fetch cycle and the cycle after it the data cycle. `data_addr`, `data_wr`, `data_short` and `wr_data` are taken at the same edge.
- R7: In the data cycle `psen_n` stays high and `ale` is high only in state 1 phase 1 and state 2 phase 0. `port_lo_out` carries `data_addr[7:0]` from state 1 phase 0 through state 2 phase 0. When `data_short`=0, `port_hi` carries `data_addr[15:8]` throughout the cycle.
- R8: For a read (`data_wr`=0), `rd_n` is low from state 2 phase 1 through state 6 phase 0 of the data cycle and high at all other times. `port_lo_oe` is 0 from state 2 phase 1 to the end of that cycle. `rd_byte` takes `bus_in` at the clock edge that ends state 6 phase 0.
- R9: For a write (`data_wr`=1), `wr_n` is low over the same window as R8 and high at all other times. `port_lo_oe` stays 1 for the whole data cycle. From state 2 phase 1 through state 6 phase 1, `port_lo_out` holds the `wr_data` value taken at acceptance.
- R10: With `data_short`=1, in the data cycle `port_hi` keeps `fetch_addr[15:8]` (default variant), and only the low port carries the data address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_addr | input | 16 | Address of the next code byte |
| data_addr | input | 16 | Data access address |
| data_req | input | 1 | Request for a data access |
| data_wr | input | 1 | Direction: 1 write, 0 read |
| data_short | input | 1 | 1 = 8-bit register-indirect form |
| ext_code | input | 1 | 1 = code is fetched from external memory |
| wr_data | input | 8 | Byte to write |
| bus_in | input | 8 | Value sensed on the low port pins |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Code read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| port_lo_out | output | 8 | Low port output value (address or write data) |
| port_lo_oe | output | 1 | Low port output enable |
| port_hi | output | 8 | High address port |
| code_byte | output | 8 | Last captured code byte |
| rd_byte | output | 8 | Last captured read data byte |
| state_num | output | 3 | Current state, 1 to 6 |
| phase_num | output | 1 | Current phase in the state, 0 or 1 |
| cycle_tick | output | 1 | High in the last clock of each machine cycle |

## Verification
The assertions assume that `ext_code` changes only at machine-cycle boundaries, so that a code-read strobe is never cut short mid-pulse. The bench changes `ext_code` and `fetch_addr` only in the first clock of a machine cycle. It changes `data_req`, the data fields and `bus_in` on any clock, so that requests arriving outside the acceptance edge and during the first access cycle are seen to be dropped. Random traffic with a fixed seed is mixed with directed runs: code from external memory, code from internal memory, a request held high continuously, and the short address form.

// File: rtl/mxb_pkg.sv
package mxb_pkg;

   typedef enum logic [1:0] {
      CYC_FETCH = 2'd0,
      CYC_LEAD  = 2'd1,
      CYC_DATA  = 2'd2
   } cyc_e;

   localparam int STATES = 6;
   localparam int PHASES = 2;
   localparam int SLOTS  = STATES * PHASES;

   function automatic int slot_of(input int st, input int ph);
      return (st - 1) * PHASES + (ph - 1);
   endfunction

   // address drive windows
   localparam int SL_ADR_A   = slot_of(1, 1);
   localparam int SL_ADR_B   = slot_of(4, 1);
   // latch strobe windows
   localparam int SL_ALE_A0  = slot_of(1, 2);
   localparam int SL_ALE_A1  = slot_of(2, 1);
   localparam int SL_ALE_B0  = slot_of(4, 2);
   localparam int SL_ALE_B1  = slot_of(5, 1);
   // code read windows
   localparam int SL_PS_A0   = slot_of(2, 2);
   localparam int SL_PS_A1   = slot_of(3, 2);
   localparam int SL_PS_B0   = slot_of(5, 2);
   localparam int SL_PS_B1   = slot_of(6, 2);
   // data strobe window
   localparam int SL_DS0     = slot_of(2, 2);
   localparam int SL_DS1     = slot_of(6, 1);
   // sampling slots
   localparam int SL_CODE_A  = SL_PS_A1;
   localparam int SL_CODE_B  = SL_PS_B1;
   localparam int SL_RD_SMP  = SL_DS1;

endpackage

// File: rtl/mxb_slot_timer.sv
module mxb_slot_timer #(
   parameter int STATES = 6,
   parameter int PHASES = 2,
   localparam int SLOTS = STATES * PHASES,
   localparam int SW    = $clog2(SLOTS),
   localparam int ST_W  = $clog2(STATES),
   localparam int SN_W  = $clog2(STATES + 1),
   localparam int PH_W  = (PHASES > 1) ? $clog2(PHASES) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [SW-1:0]   slot,
   output logic [SN_W-1:0] state_num,
   output logic [PH_W-1:0] phase_num,
   output logic            tick
);

   logic [ST_W-1:0] st_q;
   logic [PH_W-1:0] ph_q;
   logic            last_ph;
   logic            last_st;

   assign last_ph = (ph_q == PH_W'(PHASES - 1));
   assign last_st = (st_q == ST_W'(STATES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= '0;
         ph_q <= '0;
      end else if (last_ph) begin
         ph_q <= '0;
         st_q <= last_st ? '0 : st_q + 1'b1;
      end else begin
         ph_q <= ph_q + 1'b1;
      end
   end

   assign slot      = SW'(st_q) * SW'(PHASES) + SW'(ph_q);
   assign state_num = SN_W'(st_q) + SN_W'(1);
   assign phase_num = ph_q;
   assign tick      = last_ph && last_st;

endmodule

// File: rtl/mxb_cycle_ctl.sv
module mxb_cycle_ctl
   import mxb_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              data_req,
   input  logic              data_wr,
   input  logic              data_short,
   input  logic [ADDR_W-1:0] data_addr,
   input  logic [DATA_W-1:0] wr_data,
   output cyc_e              cyc,
   output logic              lat_wr,
   output logic              lat_short,
   output logic [ADDR_W-1:0] lat_addr,
   output logic [DATA_W-1:0] lat_wdata
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc       <= CYC_FETCH;
         lat_wr    <= 1'b0;
         lat_short <= 1'b0;
         lat_addr  <= '0;
         lat_wdata <= '0;
      end else if (tick) begin
         if (cyc == CYC_LEAD) begin
            cyc <= CYC_DATA;
         end else if (data_req) begin
            cyc       <= CYC_LEAD;
            lat_wr    <= data_wr;
            lat_short <= data_short;
            lat_addr  <= data_addr;
            lat_wdata <= wr_data;
         end else begin
            cyc <= CYC_FETCH;
         end
      end
   end

endmodule

// File: rtl/mxb_strobe_dec.sv
module mxb_strobe_dec
   import mxb_pkg::*;
#(
   parameter int ADDR_W        = 16,
   parameter int DATA_W        = 8,
   parameter bit SHORT_HI_ZERO = 1'b0,
   localparam int HI_W = ADDR_W - DATA_W,
   localparam int SW   = $clog2(SLOTS)
) (
   input  logic [SW-1:0]     slot,
   input  cyc_e              cyc,
   input  logic              ext_code,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic              lat_wr,
   input  logic              lat_short,
   input  logic [ADDR_W-1:0] lat_addr,
   input  logic [DATA_W-1:0] lat_wdata,
   output logic              ale,
   output logic              psen_n,
   output logic              rd_n,
   output logic              wr_n,
   output logic [DATA_W-1:0] lo_out,
   output logic              lo_oe,
   output logic [HI_W-1:0]   hi_out
);

   function automatic logic in_win(input logic [SW-1:0] s, input int lo, input int hi);
      return (int'(s) >= lo) && (int'(s) <= hi);
   endfunction

   logic [HI_W-1:0] short_hi;

   generate
      if (SHORT_HI_ZERO) begin : g_hi_zero
         assign short_hi = '0;
      end else begin : g_hi_keep
         assign short_hi = fetch_addr[ADDR_W-1:DATA_W];
      end
   endgenerate

   logic data_cyc;
   logic addr_ph;
   logic fetch_win;
   logic strobe_win;

   always_comb begin
      data_cyc   = (cyc == CYC_DATA);
      addr_ph    = in_win(slot, SL_ADR_A, SL_ALE_A1) ||
                   (!data_cyc && in_win(slot, SL_ADR_B, SL_ALE_B1));
      fetch_win  = in_win(slot, SL_PS_A0, SL_PS_A1) || in_win(slot, SL_PS_B0, SL_PS_B1);
      strobe_win = data_cyc && in_win(slot, SL_DS0, SL_DS1);

      ale    = in_win(slot, SL_ALE_A0, SL_ALE_A1) ||
               (!data_cyc && in_win(slot, SL_ALE_B0, SL_ALE_B1));
      psen_n = !(ext_code && !data_cyc && fetch_win);
      rd_n   = !(strobe_win && !lat_wr);
      wr_n   = !(strobe_win && lat_wr);
      lo_oe  = addr_ph || (data_cyc && lat_wr && in_win(slot, SL_DS0, SLOTS - 1));

      if (!lo_oe)
         lo_out = '0;
      else if (data_cyc)
         lo_out = addr_ph ? lat_addr[DATA_W-1:0] : lat_wdata;
      else
         lo_out = fetch_addr[DATA_W-1:0];

      if (data_cyc)
         hi_out = lat_short ? short_hi : lat_addr[ADDR_W-1:DATA_W];
      else
         hi_out = fetch_addr[ADDR_W-1:DATA_W];
   end

endmodule

// File: rtl/mxb_capture.sv
module mxb_capture
   import mxb_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int SW    = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SW-1:0]     slot,
   input  cyc_e              cyc,
   input  logic              ext_code,
   input  logic              lat_wr,
   input  logic [DATA_W-1:0] bus_in,
   output logic [DATA_W-1:0] code_byte,
   output logic [DATA_W-1:0] rd_byte
);

   logic code_smp;
   logic rd_smp;

   assign code_smp = ext_code && (cyc != CYC_DATA) &&
                     ((slot == SW'(SL_CODE_A)) || (slot == SW'(SL_CODE_B)));
   assign rd_smp   = (cyc == CYC_DATA) && !lat_wr && (slot == SW'(SL_RD_SMP));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_byte <= '0;
         rd_byte   <= '0;
      end else begin
         if (code_smp) code_byte <= bus_in;
         if (rd_smp)   rd_byte   <= bus_in;
      end
   end

endmodule

// File: rtl/mxb_bus_seq.sv
module mxb_bus_seq
   import mxb_pkg::*;
#(
   parameter int ADDR_W        = 16,
   parameter int DATA_W        = 8,
   parameter bit SHORT_HI_ZERO = 1'b0,
   localparam int HI_W = ADDR_W - DATA_W,
   localparam int SW   = $clog2(SLOTS),
   localparam int SN_W = $clog2(STATES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic [ADDR_W-1:0] data_addr,
   input  logic              data_req,
   input  logic              data_wr,
   input  logic              data_short,
   input  logic              ext_code,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] bus_in,
   output logic              ale,
   output logic              psen_n,
   output logic              rd_n,
   output logic              wr_n,
   output logic [DATA_W-1:0] port_lo_out,
   output logic              port_lo_oe,
   output logic [HI_W-1:0]   port_hi,
   output logic [DATA_W-1:0] code_byte,
   output logic [DATA_W-1:0] rd_byte,
   output logic [SN_W-1:0]   state_num,
   output logic              phase_num,
   output logic              cycle_tick
);

   generate
      if (DATA_W < 1) begin : g_bad_data_w
         $error("mxb_bus_seq: DATA_W must be at least 1");
      end
      if (ADDR_W <= DATA_W) begin : g_bad_addr_w
         $error("mxb_bus_seq: ADDR_W must exceed DATA_W");
      end
      if (PHASES != 2 || STATES != 6) begin : g_bad_frame
         $error("mxb_bus_seq: strobe windows assume six states of two phases");
      end
   endgenerate

   logic [SW-1:0]     slot;
   cyc_e              cyc;
   logic              lat_wr;
   logic              lat_short;
   logic [ADDR_W-1:0] lat_addr;
   logic [DATA_W-1:0] lat_wdata;

   mxb_slot_timer #(.STATES(STATES), .PHASES(PHASES)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .slot      (slot),
      .state_num (state_num),
      .phase_num (phase_num),
      .tick      (cycle_tick)
   );

   mxb_cycle_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (cycle_tick),
      .data_req   (data_req),
      .data_wr    (data_wr),
      .data_short (data_short),
      .data_addr  (data_addr),
      .wr_data    (wr_data),
      .cyc        (cyc),
      .lat_wr     (lat_wr),
      .lat_short  (lat_short),
      .lat_addr   (lat_addr),
      .lat_wdata  (lat_wdata)
   );

   mxb_strobe_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SHORT_HI_ZERO(SHORT_HI_ZERO)) u_dec (
      .slot       (slot),
      .cyc        (cyc),
      .ext_code   (ext_code),
      .fetch_addr (fetch_addr),
      .lat_wr     (lat_wr),
      .lat_short  (lat_short),
      .lat_addr   (lat_addr),
      .lat_wdata  (lat_wdata),
      .ale        (ale),
      .psen_n     (psen_n),
      .rd_n       (rd_n),
      .wr_n       (wr_n),
      .lo_out     (port_lo_out),
      .lo_oe      (port_lo_oe),
      .hi_out     (port_hi)
   );

   mxb_capture #(.DATA_W(DATA_W)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .slot      (slot),
      .cyc       (cyc),
      .ext_code  (ext_code),
      .lat_wr    (lat_wr),
      .bus_in    (bus_in),
      .code_byte (code_byte),
      .rd_byte   (rd_byte)
   );

endmodule

// File: rtl/mxb_bus_seq_chk.sv
module mxb_bus_seq_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ext_code,
   input logic              ale,
   input logic              psen_n,
   input logic              rd_n,
   input logic              wr_n,
   input logic              port_lo_oe,
   input logic [DATA_W-1:0] port_lo_out,
   input logic [2:0]        state_num,
   input logic              phase_num,
   input logic              cycle_tick
);

   assert_tick_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_tick |-> (state_num == 3'd6 && phase_num == 1'b1));

   assert_tick_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_tick |=> (state_num == 3'd1 && phase_num == 1'b0));

   assert_ale_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ale) |-> (phase_num == 1'b1 && (state_num == 3'd1 || state_num == 3'd4)));

   assert_ale_alone_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> (psen_n && rd_n && wr_n));

   assert_int_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_code |-> psen_n);

   assert_no_fetch_in_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !psen_n |-> (rd_n && wr_n));

   assert_rd_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> (!port_lo_oe && wr_n));

   assert_wr_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |-> port_lo_oe);

   assert_wr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_n && $past(!wr_n)) |-> $stable(port_lo_out));

endmodule

bind mxb_bus_seq mxb_bus_seq_chk #(.DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ext_code    (ext_code),
   .ale         (ale),
   .psen_n      (psen_n),
   .rd_n        (rd_n),
   .wr_n        (wr_n),
   .port_lo_oe  (port_lo_oe),
   .port_lo_out (port_lo_out),
   .state_num   (state_num),
   .phase_num   (phase_num),
   .cycle_tick  (cycle_tick)
);

// File: tb/tb_mxb_bus_seq.sv
`timescale 1ns/1ps
module tb_mxb_bus_seq;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] fetch_addr, data_addr;
   logic        data_req, data_wr, data_short, ext_code;
   logic [7:0]  wr_data, bus_in;
   logic        ale, psen_n, rd_n, wr_n, port_lo_oe, phase_num, cycle_tick;
   logic [7:0]  port_lo_out, port_hi, code_byte, rd_byte;
   logic [2:0]  state_num;

   always #4 clk = ~clk;

   mxb_bus_seq dut (
      .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .data_addr(data_addr),
      .data_req(data_req), .data_wr(data_wr), .data_short(data_short),
      .ext_code(ext_code), .wr_data(wr_data), .bus_in(bus_in),
      .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
      .port_lo_out(port_lo_out), .port_lo_oe(port_lo_oe), .port_hi(port_hi),
      .code_byte(code_byte), .rd_byte(rd_byte), .state_num(state_num),
      .phase_num(phase_num), .cycle_tick(cycle_tick)
   );

   int checks = 0;
   int errs   = 0;
   bit done   = 0;

   // reference model state
   int          ms;     // slot 0..11
   int          mk;     // 0 fetch, 1 first access cycle, 2 data cycle
   logic [15:0] m_addr;
   logic        m_wr, m_short;
   logic [7:0]  m_wdata, m_code, m_rd;

   // stimulus controls
   int req_mode;    // 0 never, 1 always, 2 random
   int ext_mode;    // 0 fixed, 1 random
   bit ext_fixed;
   int short_mode;  // 0 random, 1 forced 1

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic bit in_rng(input int s, input int lo, input int hi);
      return s >= lo && s <= hi;
   endfunction

   task automatic check_all();
      bit e_ale, e_psen_n, e_rd_n, e_wr_n, e_oe;
      logic [7:0] e_lo, e_hi;
      string t_lo, t_hi, t_ps;
      if (mk == 2) begin
         e_ale    = in_rng(ms, 1, 2);
         e_psen_n = 1'b1;
         e_rd_n   = !(!m_wr && in_rng(ms, 3, 10));
         e_wr_n   = !(m_wr && in_rng(ms, 3, 10));
         e_oe     = (ms <= 2) || m_wr;
         e_lo     = (ms <= 2) ? m_addr[7:0] : m_wdata;
         e_hi     = m_short ? fetch_addr[15:8] : m_addr[15:8];
         t_lo     = (ms <= 2) ? "R7" : "R9";
         t_hi     = m_short ? "R10" : "R7";
         t_ps     = "R7";
      end else begin
         e_ale    = in_rng(ms, 1, 2) || in_rng(ms, 7, 8);
         e_psen_n = !(ext_code && (in_rng(ms, 3, 5) || in_rng(ms, 9, 11)));
         e_rd_n   = 1'b1;
         e_wr_n   = 1'b1;
         e_oe     = in_rng(ms, 0, 2) || in_rng(ms, 6, 8);
         e_lo     = fetch_addr[7:0];
         e_hi     = fetch_addr[15:8];
         t_lo     = "R5";
         t_hi     = "R5";
         t_ps     = ext_code ? "R3" : "R4";
      end
      chk("R1", "state_num", 32'(state_num), 32'(ms / 2 + 1));
      chk("R1", "phase_num", 32'(phase_num), 32'(ms % 2));
      chk("R1", "cycle_tick", 32'(cycle_tick), 32'(ms == 11));
      chk((mk == 2) ? "R7" : "R2", "ale", 32'(ale), 32'(e_ale));
      chk(t_ps, "psen_n", 32'(psen_n), 32'(e_psen_n));
      chk("R8", "rd_n", 32'(rd_n), 32'(e_rd_n));
      chk("R9", "wr_n", 32'(wr_n), 32'(e_wr_n));
      chk((mk == 2) ? (m_wr ? "R9" : "R8") : "R5", "port_lo_oe", 32'(port_lo_oe), 32'(e_oe));
      if (e_oe) chk(t_lo, "port_lo_out", 32'(port_lo_out), 32'(e_lo));
      chk(t_hi, "port_hi", 32'(port_hi), 32'(e_hi));
      chk(ext_code ? "R3" : "R4", "code_byte", 32'(code_byte), 32'(m_code));
      chk("R8", "rd_byte", 32'(rd_byte), 32'(m_rd));
      if (ms == 3)  // R6: a data cycle exactly when the model says so
         chk("R6", "data strobe present", 32'(!(rd_n && wr_n)), 32'(mk == 2));
   endtask

   task automatic model_edge();
      if (mk != 2 && ext_code && (ms == 5 || ms == 11)) m_code = bus_in;
      if (mk == 2 && !m_wr && ms == 10) m_rd = bus_in;
      if (ms == 11) begin
         if (mk == 1) mk = 2;
         else if (data_req) begin
            mk = 1; m_addr = data_addr; m_wr = data_wr;
            m_short = data_short; m_wdata = wr_data;
         end else mk = 0;
      end
      ms = (ms + 1) % 12;
   endtask

   task automatic drive_boundary();
      fetch_addr = 16'($urandom);
      ext_code   = (ext_mode == 1) ? 1'($urandom) : ext_fixed;
   endtask

   task automatic drive_rest();
      bus_in     = 8'($urandom);
      data_addr  = 16'($urandom);
      data_wr    = 1'($urandom);
      wr_data    = 8'($urandom);
      data_short = (short_mode == 1) ? 1'b1 : 1'($urandom);
      case (req_mode)
         0:       data_req = 1'b0;
         1:       data_req = 1'b1;
         default: data_req = ($urandom % 100) < 20;
      endcase
   endtask

   task automatic run_cycles(input int n);
      for (int i = 0; i < n * 12; i++) begin
         @(posedge clk);
         model_edge();
         @(negedge clk);
         if (ms == 0) drive_boundary();
         #1;
         check_all();
         drive_rest();
      end
   endtask

   initial begin
      int seed_junk;
      seed_junk = $urandom(32'h5EED_0B05);
      rst_n = 1'b0;
      req_mode = 0; ext_mode = 0; ext_fixed = 1'b1; short_mode = 0;
      ms = 0; mk = 0; m_addr = '0; m_wr = 0; m_short = 0; m_wdata = '0;
      m_code = '0; m_rd = '0;
      drive_boundary();
      drive_rest();
      repeat (3) @(negedge clk);
      #1;
      check_all();            // R1 reset state
      rst_n = 1'b1;
      // R3: external code, no data traffic
      run_cycles(4);
      // R4: internal code, fetch strobe quiet, code_byte held
      ext_fixed = 1'b0;
      run_cycles(3);
      // R6: request held high, back-to-back accesses, second request dropped
      ext_fixed = 1'b1; req_mode = 1;
      run_cycles(8);
      // R10: short address form
      short_mode = 1;
      run_cycles(6);
      // mixed random traffic for R2, R5, R7, R8, R9
      short_mode = 0; req_mode = 2; ext_mode = 1;
      run_cycles(300);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         errs++;
         checks++;
         $display("FAIL R1 watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

endmodule